// File: doc/BRIEF.md
# Transfer Negotiation Message Builder

This block assembles the outgoing extended message that an initiator sends to propose either a wider data bus or synchronous transfer timing to a target. A controller pulses `start_i` with the two request flags and the per-target settings present; the block chooses one message, composes its bytes and streams them out one per accepted beat. These bytes are appended to a message buffer that may already hold a one-byte identify and an optional two-byte tag. When the last byte has been accepted, `done_o` pulses and `msg_len_o` reports the full buffer length (bytes already present plus bytes written).

Only one negotiation is built per start. Bus width takes priority, so that a reject from the target can always be paired with a single outstanding proposal. The synchronous offer carries a period computed from a 3-bit rate code and an offset. The offset is either taken from the rate settings or forced to the largest value the device width allows, and in the latter case the block asks the controller to drop its sticky max-offset flag.

The byte output is a valid/ready stream. Once `out_valid_o` is high, it and `out_data_o` hold steady until `out_ready_i` is sampled high at a rising edge, and a byte counts as transferred only on such an edge. No bytes are dropped or repeated under back-pressure. The stream never waits for `out_ready_i` before raising valid.

Top module: `nego_msg_builder`

## Requirements
- R1: A start with neither request flag set emits no byte; `done_o` pulses on the cycle after the start is sampled and `msg_len_o` equals `prefix_len_i`.
- R2: With the wide request set, only the width message is emitted, whatever the sync request, self-initiate or max-offset inputs say, and `max_clr_o` stays low.
- R3: The width message is four bytes in order: 0x01, 0x02, 0x03, then `width_arg_i`.
- R4: The synchronous message is five bytes in order: 0x01, 0x03, 0x01, the period byte, the offset byte.
- R5: With code n = `tgt_rate_i[6:4]`, the period byte is ((n*24) >> 2) + 24, i.e. 6n + 24.
- R6: When `ultra_en_i` is high, the period byte from R5 is shifted right by one (floor of half).
- R7: Without max-offset mode, the offset byte is `tgt_rate_i[3:0]` zero-extended, for either device width.
- R8: Max-offset mode is in force when `self_init_i` or `max_off_i` is high; the offset byte is then 0x0F for an 8-bit device (`wide_dev_i` low, bit 7 of the current rate) or 0x08 for a wide device, and `max_clr_o` pulses together with `done_o`.
- R9: At `done_o`, `msg_len_o` equals `prefix_len_i` (captured at start) plus the number of bytes emitted, and holds that value until the next accepted start.
- R10: While `out_valid_o` is high and `out_ready_i` low, the next cycle still shows `out_valid_o` high with unchanged `out_data_o`; each accepted beat moves to the next byte.
- R11: A start pulse while `busy_o` is high is ignored: the message in flight, its length and its single `done_o` are unaffected.
- R12: After reset, `out_valid_o`, `busy_o`, `done_o` and `max_clr_o` are low and `msg_len_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Build request, sampled when idle |
| req_wide_i | input | 1 | Width negotiation wanted |
| req_sync_i | input | 1 | Synchronous negotiation wanted |
| tgt_rate_i | input | 7 | Per-target rate: [6:4] period code, [3:0] offset |
| wide_dev_i | input | 1 | Device is 16-bit (bit 7 of the current rate) |
| ultra_en_i | input | 1 | Fast mode: halve period |
| self_init_i | input | 1 | Sync negotiation started by this side |
| max_off_i | input | 1 | Sticky max-offset request |
| width_arg_i | input | 8 | Width argument for the width message |
| prefix_len_i | input | PFX_W (2) | Bytes already in the buffer |
| out_valid_o | output | 1 | Byte stream valid |
| out_ready_i | input | 1 | Byte stream ready |
| out_data_o | output | 8 | Byte stream data |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | One-cycle completion pulse |
| msg_len_o | output | LEN_W (4) | Total buffer length |
| max_clr_o | output | 1 | Clear the max-offset flag (with done) |

## Verification
The hardest situation to reach is a start arriving while a message is still draining under back-pressure, since it must change neither the bytes nor the length nor produce a second completion. The bench injects such a pulse, with contradictory request flags and a different prefix, in the middle of a stalled stream, then watches several idle cycles after completion. The stimulus table alternates a stalling ready pattern with a free-flowing one so that every message format is also seen held across stalls.

// File: rtl/nego_pkg.sv
package nego_pkg;
  localparam int BYTE_W  = 8;
  localparam int MSG_MAX = 5;
  localparam int CNT_W   = $clog2(MSG_MAX + 1);

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_WIDE = 2'd1,
    KIND_SYNC = 2'd2
  } nego_kind_e;

  localparam logic [BYTE_W-1:0] EXT_INTRO  = 8'h01;
  localparam logic [BYTE_W-1:0] WIDE_XLEN  = 8'h02;
  localparam logic [BYTE_W-1:0] WIDE_CODE  = 8'h03;
  localparam logic [BYTE_W-1:0] SYNC_XLEN  = 8'h03;
  localparam logic [BYTE_W-1:0] SYNC_CODE  = 8'h01;
  localparam logic [BYTE_W-1:0] OFF_MAX_N  = 8'h0f;
  localparam logic [BYTE_W-1:0] OFF_MAX_W  = 8'h08;
  localparam logic [CNT_W-1:0]  WIDE_BYTES = CNT_W'(4);
  localparam logic [CNT_W-1:0]  SYNC_BYTES = CNT_W'(5);

  // period byte: scaled rate code plus base, optionally halved
  function automatic logic [BYTE_W-1:0] offer_period(input logic [2:0] code,
                                                     input logic ultra);
    logic [BYTE_W-1:0] scaled;
    scaled = ({5'd0, code} * 8'd24) >> 2;
    scaled = scaled + 8'd24;
    return ultra ? (scaled >> 1) : scaled;
  endfunction
endpackage

// File: rtl/nego_select.sv
module nego_select
  import nego_pkg::*;
(
  input  logic       req_wide,
  input  logic       req_sync,
  input  logic       self_init,
  input  logic       max_flag,
  output nego_kind_e kind,
  output logic       max_mode
);
  always_comb begin
    if (req_wide)      kind = KIND_WIDE;
    else if (req_sync) kind = KIND_SYNC;
    else               kind = KIND_NONE;
    max_mode = (kind == KIND_SYNC) && (self_init || max_flag);
  end
endmodule

// File: rtl/nego_compose.sv
module nego_compose
  import nego_pkg::*;
(
  input  nego_kind_e                      kind,
  input  logic [6:0]                      rate,
  input  logic                            wide_dev,
  input  logic                            ultra,
  input  logic                            max_mode,
  input  logic [BYTE_W-1:0]               width_arg,
  output logic [MSG_MAX-1:0][BYTE_W-1:0]  msg,
  output logic [CNT_W-1:0]                count,
  output logic                            used_max
);
  logic [BYTE_W-1:0] period_b;
  logic [BYTE_W-1:0] offset_b;
  logic [BYTE_W-1:0] cap_b;

  always_comb begin
    period_b = offer_period(rate[6:4], ultra);
    cap_b    = wide_dev ? OFF_MAX_W : OFF_MAX_N;
    offset_b = max_mode ? cap_b : {4'd0, rate[3:0]};
  end

  always_comb begin
    msg      = '0;
    count    = '0;
    used_max = 1'b0;
    unique case (kind)
      KIND_WIDE: begin
        msg[0] = EXT_INTRO;
        msg[1] = WIDE_XLEN;
        msg[2] = WIDE_CODE;
        msg[3] = width_arg;
        count  = WIDE_BYTES;
      end
      KIND_SYNC: begin
        msg[0]   = EXT_INTRO;
        msg[1]   = SYNC_XLEN;
        msg[2]   = SYNC_CODE;
        msg[3]   = period_b;
        msg[4]   = offset_b;
        count    = SYNC_BYTES;
        used_max = max_mode;
      end
      default: begin
        count = '0;
      end
    endcase
  end
endmodule

// File: rtl/nego_emitter.sv
module nego_emitter
  import nego_pkg::*;
#(
  parameter int PFX_W = 2,
  parameter int LEN_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [MSG_MAX-1:0][BYTE_W-1:0] msg_d,
  input  logic [CNT_W-1:0]               count_d,
  input  logic                           clr_d,
  input  logic [PFX_W-1:0]               prefix_d,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic [BYTE_W-1:0]              out_data_o,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [LEN_W-1:0]               msg_len_o,
  output logic                           max_clr_o
);
  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} emit_st_e;

  emit_st_e                       st_q;
  logic [MSG_MAX-1:0][BYTE_W-1:0] msg_q;
  logic [CNT_W-1:0]               cnt_q;
  logic [CNT_W-1:0]               idx_q;
  logic                           clr_q;
  logic                           done_q;
  logic                           mclr_q;
  logic [LEN_W-1:0]               len_q;
  logic                           accept;
  logic                           beat;
  logic                           last_beat;

  assign accept    = start_i && (st_q == ST_IDLE);
  assign beat      = (st_q == ST_SEND) && out_ready_i;
  assign last_beat = beat && (idx_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      msg_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
      mclr_q <= 1'b0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      mclr_q <= 1'b0;
      if (accept) begin
        msg_q <= msg_d;
        cnt_q <= count_d;
        idx_q <= '0;
        clr_q <= clr_d;
        len_q <= LEN_W'(prefix_d) + LEN_W'(count_d);
        if (count_d == '0) begin
          done_q <= 1'b1;
          mclr_q <= clr_d;
        end else begin
          st_q <= ST_SEND;
        end
      end else if (beat) begin
        if (last_beat) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          mclr_q <= clr_q;
        end else begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    out_data_o = '0;
    for (int k = 0; k < MSG_MAX; k++) begin
      if (idx_q == CNT_W'(k)) out_data_o = msg_q[k];
    end
  end

  assign out_valid_o = (st_q == ST_SEND);
  assign busy_o      = (st_q == ST_SEND);
  assign done_o      = done_q;
  assign max_clr_o   = mclr_q;
  assign msg_len_o   = len_q;
endmodule

// File: rtl/nego_msg_builder.sv
module nego_msg_builder
  import nego_pkg::*;
#(
  parameter  int PFX_W = 2,
  localparam int LEN_W = $clog2((1 << PFX_W) - 1 + MSG_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_wide_i,
  input  logic              req_sync_i,
  input  logic [6:0]        tgt_rate_i,
  input  logic              wide_dev_i,
  input  logic              ultra_en_i,
  input  logic              self_init_i,
  input  logic              max_off_i,
  input  logic [7:0]        width_arg_i,
  input  logic [PFX_W-1:0]  prefix_len_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  msg_len_o,
  output logic              max_clr_o
);
  nego_kind_e                     kind;
  logic                           max_mode;
  logic [MSG_MAX-1:0][BYTE_W-1:0] msg;
  logic [CNT_W-1:0]               count;
  logic                           used_max;

  nego_select u_select (
    .req_wide  (req_wide_i),
    .req_sync  (req_sync_i),
    .self_init (self_init_i),
    .max_flag  (max_off_i),
    .kind      (kind),
    .max_mode  (max_mode)
  );

  nego_compose u_compose (
    .kind      (kind),
    .rate      (tgt_rate_i),
    .wide_dev  (wide_dev_i),
    .ultra     (ultra_en_i),
    .max_mode  (max_mode),
    .width_arg (width_arg_i),
    .msg       (msg),
    .count     (count),
    .used_max  (used_max)
  );

  nego_emitter #(.PFX_W(PFX_W), .LEN_W(LEN_W)) u_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .msg_d       (msg),
    .count_d     (count),
    .clr_d       (used_max),
    .prefix_d    (prefix_len_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .msg_len_o   (msg_len_o),
    .max_clr_o   (max_clr_o)
  );
endmodule

// File: rtl/nego_msg_builder_chk.sv
module nego_msg_builder_chk #(
  parameter int PFX_W = 2,
  parameter int LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [PFX_W-1:0] prefix_len_i,
  input logic             req_wide_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [LEN_W-1:0] msg_len_o,
  input logic             max_clr_o
);
  logic [2:0]       beats_q;
  logic [PFX_W-1:0] pfx_q;
  logic             wide_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      beats_q <= '0;
      pfx_q   <= '0;
      wide_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      beats_q <= '0;
      pfx_q   <= prefix_len_i;
      wide_q  <= req_wide_i;
    end else if (out_valid_o && out_ready_i) begin
      beats_q <= beats_q + 3'd1;
    end
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R3
  intro_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && beats_q == 3'd0 |-> out_data_o == 8'h01);

  // R9
  len_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> msg_len_o == LEN_W'(pfx_q) + LEN_W'(beats_q));

  // R9
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i && !done_o |=> $stable(msg_len_o));

  // R8
  clr_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_clr_o |-> done_o);

  // R2
  wide_no_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && wide_q |-> !max_clr_o && beats_q == 3'd4);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o && !busy_o);

  // R4
  beat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> beats_q < 3'd5);
endmodule

bind nego_msg_builder nego_msg_builder_chk #(.PFX_W(PFX_W), .LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .prefix_len_i (prefix_len_i),
  .req_wide_i   (req_wide_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_data_o   (out_data_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .msg_len_o    (msg_len_o),
  .max_clr_o    (max_clr_o)
);

// File: tb/nego_msg_builder_test.sv
module nego_msg_builder_test;
  typedef struct packed {
    logic        w;
    logic        s;
    logic [6:0]  rate;
    logic        wdev;
    logic        ultra;
    logic        selfi;
    logic        maxf;
    logic [1:0]  pfx;
    logic [7:0]  width;
    logic [2:0]  n;
    logic [39:0] bytes;
    logic [3:0]  len;
    logic        mclr;
  } vec_t;

  localparam int NV = 9;
  // expected bytes: first byte in [39:32]
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,7'h35,1'b0,1'b0,1'b0,1'b0,2'd1,8'h00,3'd0,40'h0000000000,4'd1,1'b0}, // R1
    '{1'b1,1'b0,7'h35,1'b0,1'b0,1'b0,1'b0,2'd1,8'h01,3'd4,40'h0102030100,4'd5,1'b0}, // R3
    '{1'b1,1'b1,7'h25,1'b1,1'b1,1'b1,1'b1,2'd3,8'h00,3'd4,40'h0102030000,4'd7,1'b0}, // R2
    '{1'b0,1'b1,7'h25,1'b0,1'b0,1'b0,1'b0,2'd1,8'h00,3'd5,40'h0103012405,4'd6,1'b0}, // R4 R5 R7
    '{1'b0,1'b1,7'h7a,1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,3'd5,40'h010301210a,4'd5,1'b0}, // R6
    '{1'b0,1'b1,7'h03,1'b0,1'b1,1'b1,1'b0,2'd3,8'h00,3'd5,40'h0103010c0f,4'd8,1'b1}, // R8 narrow
    '{1'b0,1'b1,7'h1c,1'b1,1'b0,1'b0,1'b1,2'd2,8'h00,3'd5,40'h0103011e08,4'd7,1'b1}, // R8 wide
    '{1'b0,1'b1,7'h50,1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,3'd5,40'h0103011b00,4'd5,1'b0}, // R6
    '{1'b0,1'b1,7'h6f,1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,3'd5,40'h0103013c0f,4'd5,1'b0}  // R7 wide
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rw = 1'b0, rs = 1'b0, wdev = 1'b0, ultra = 1'b0, selfi = 1'b0, maxf = 1'b0;
  logic [6:0] rate = '0;
  logic [7:0] width = '0;
  logic [1:0] pfx = '0;
  logic       ready = 1'b0;
  logic       valid, busy, done, mclr;
  logic [7:0] data;
  logic [3:0] len;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nego_msg_builder uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_wide_i(rw), .req_sync_i(rs),
    .tgt_rate_i(rate), .wide_dev_i(wdev), .ultra_en_i(ultra), .self_init_i(selfi),
    .max_off_i(maxf), .width_arg_i(width), .prefix_len_i(pfx),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(data), .busy_o(busy),
    .done_o(done), .msg_len_o(len), .max_clr_o(mclr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string byte_tag(input vec_t v, input int k);
    if (v.w) return "R2/R3";
    if (k == 3) return "R5/R6";
    if (k == 4) return v.mclr ? "R8" : "R7";
    return "R4";
  endfunction

  task automatic run_vec(input vec_t v, input bit stall, input bit poke);
    int   got = 0;
    bit   held = 1'b0;
    logic [7:0] held_data = '0;
    bit   seen_done = 1'b0;
    @(negedge clk);
    rw = v.w; rs = v.s; rate = v.rate; wdev = v.wdev; ultra = v.ultra;
    selfi = v.selfi; maxf = v.maxf; width = v.width; pfx = v.pfx; start = 1'b1;
    ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 40 && !seen_done; cyc++) begin
      if (held) check(valid && data == held_data, "R10 stall hold", data, held_data);
      held = 1'b0;
      if (mclr && !done) check(1'b0, "R8 clear without done", mclr, 0);
      if (done) begin
        seen_done = 1'b1;
        check(got == v.n, "R1/R2 byte count", got, v.n);
        check(len == v.len, "R9 length", len, v.len);
        check(mclr == v.mclr, "R8 max clear", mclr, v.mclr);
        check(!valid, "R10 valid after done", valid, 0);
        ready = 1'b0;
      end else begin
        if (poke && cyc == 1) begin
          start = 1'b1; rw = 1'b0; rs = 1'b0; pfx = 2'd0; // R11 injected
        end else begin
          start = 1'b0; rw = v.w; rs = v.s; pfx = v.pfx;
        end
        ready = stall ? cyc[0] : 1'b1;
        if (valid) begin
          logic [7:0] exp_b;
          exp_b = (got < 5) ? v.bytes[39 - 8*got -: 8] : 8'hxx;
          check(got < v.n && data == exp_b, byte_tag(v, got), data, exp_b);
          if (ready) got++;
          else begin held = 1'b1; held_data = data; end
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    if (!seen_done) check(1'b0, "R1 no done pulse", 0, 1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(!done && !valid, "R11 extra activity", {valid, done}, 0);
      check(len == v.len, "R9 length hold", len, v.len);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!valid && !busy && !done && !mclr, "R12 reset outputs", {valid, busy, done, mclr}, 0);
    check(len == 4'd0, "R12 reset length", len, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !busy && len == 4'd0, "R12 after release", {valid, busy}, 0);
    for (int i = 0; i < NV; i++) run_vec(TBL[i], i[0], 1'b0);
    // directed: start pulse while busy, stalled and free-running
    run_vec(TBL[5], 1'b1, 1'b1);
    run_vec(TBL[1], 1'b0, 1'b1);
    // directed: back-to-back empty builds, prefix at its maximum
    run_vec('{1'b0,1'b0,7'h7f,1'b1,1'b1,1'b1,1'b1,2'd3,8'hff,3'd0,40'h0,4'd3,1'b0}, 1'b0, 1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule